// File: doc/BRIEF.md
# Micro-op Dispatch Router

This block sits between an out-of-order dispatch window and the issue queues of the execution ports. Each cycle it looks at a window of up to eight ready micro-ops, ordered oldest (slot 0) to youngest. Each micro-op carries a class tag that names the port queue it must go to. Six execution ports each own a dedicated queue. The two load/store ports share one combined queue that can take two entries in a cycle.

The router grants micro-ops strictly in age order, as far as queue capacity and the queue status inputs allow. The first slot that cannot be granted ends the grant run, so younger micro-ops never overtake an older stalled one. The per-slot accept mask goes back to the window in the same cycle. The queue write enables and the routed payloads are registered and appear on the next clock edge. A full dispatch of eight is only possible when the window holds one micro-op for every dedicated port plus two load/store micro-ops.

Top module: `dispatch_router`

## Requirements
- R1: Slot 0 is the oldest. `acceptMask` is always a contiguous run of ones starting at bit 0. A slot that is not granted ends the run for every younger slot.
- R2: A dedicated queue (class tag 0 to 5, the tag being the queue index) receives at most one micro-op per cycle. A second micro-op of the same class is not granted.
- R3: The combined load/store queue (class tag 6) receives up to two micro-ops per cycle. A third load/store micro-op in the same cycle is not granted.
- R4: While `lsRoomOne` is high, the load/store queue receives at most one micro-op per cycle.
- R5: A queue whose full input (`dedFull[q]` or `lsFull`) is high receives no grant. The micro-op that targets it is not accepted.
- R6: An invalid slot, or a class tag of 7 (no queue), is not granted.
- R7: A micro-op granted in a cycle is written one cycle later. Its queue's write enable goes high, and its payload appears on that queue's data lane. When two load/store micro-ops are written, the older one is on lane 0 (bits 15:0 of `lsWrData`) and the younger one on lane 1 (bits 31:16). Dedicated queue q uses bits q*16+15 to q*16 of `dedWrData`.
- R8: A window holding one micro-op for each of the six dedicated classes and two load/store micro-ops, in any order, with no queue full, is accepted in full (`acceptMask` = 8'hFF).
- R9: While `rst_n` is low, all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slotValid | input | 8 | Valid bit per window slot, bit 0 oldest |
| slotClass | input | 24 | 3-bit class tag per slot, slot i at bits 3i+2 to 3i |
| slotPayload | input | 128 | 16-bit payload per slot, slot i at bits 16i+15 to 16i |
| dedFull | input | 6 | Full status of each dedicated queue |
| lsFull | input | 1 | Combined load/store queue is full |
| lsRoomOne | input | 1 | Load/store queue has room for only one entry |
| acceptMask | output | 8 | Per-slot grant, same cycle |
| dedWrEn | output | 6 | Registered write enable per dedicated queue |
| dedWrData | output | 96 | Registered payload per dedicated queue |
| lsWrEn | output | 2 | Registered write enable per load/store lane |
| lsWrData | output | 32 | Registered payload per load/store lane |

## Verification
The bench targets the places where in-order grants break. A second micro-op of the same dedicated class must stall the micro-ops behind it. A wrong design would grant the younger ones and return a mask with holes. A third load/store micro-op, or a second one while only one entry is free, must stall. A design that miscounts lanes would overfill the combined queue or drop a lane. A full queue, a gap in the valid bits and the unrouted tag must each end the run. A design that skips over them would dispatch out of order. A complete mixed window must go through at full width with the older load/store payload on lane 0. A design that swaps the lanes or routes through the wrong multiplexer leg would show the wrong payloads one cycle later.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int WINDOW     = 8;
  localparam int DED_QUEUES = 6;
  localparam int LS_LANES   = 2;
  localparam int CLASS_W    = 3;
  localparam int PAY_W      = 16;
  localparam int SLOT_IDX_W = $clog2(WINDOW);
  localparam int LS_CNT_W   = $clog2(LS_LANES + 1);

  typedef struct packed {
    logic [WINDOW-1:0]                        grant;
    logic [DED_QUEUES-1:0]                    dedWe;
    logic [DED_QUEUES-1:0][SLOT_IDX_W-1:0]    dedSrc;
    logic [LS_LANES-1:0]                      lsWe;
    logic [LS_LANES-1:0][SLOT_IDX_W-1:0]      lsSrc;
  } grantStrobes_t;
endpackage

// File: rtl/dispatch_grant_ctrl.sv
module dispatch_grant_ctrl
  import dispatch_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WINDOW-1:0]           slotValid,
  input  logic [WINDOW*CLASS_W-1:0]   slotClass,
  input  logic [DED_QUEUES-1:0]       dedFull,
  input  logic                        lsFull,
  input  logic                        lsRoomOne,
  output grantStrobes_t               strobes
);
  localparam logic [CLASS_W-1:0] LS_TAG = CLASS_W'(DED_QUEUES);

  logic                  stopRun;
  logic                  canGrant;
  logic [CLASS_W-1:0]    cls;
  logic [DED_QUEUES-1:0] dedUsed;
  logic [LS_CNT_W-1:0]   lsCount;
  logic [LS_CNT_W-1:0]   lsCap;

  // Walk the window oldest first; the first refusal ends the run.
  always_comb begin
    strobes  = '0;
    stopRun  = 1'b0;
    dedUsed  = '0;
    lsCount  = '0;
    canGrant = 1'b0;
    cls      = '0;
    lsCap    = lsRoomOne ? LS_CNT_W'(1) : LS_CNT_W'(LS_LANES);
    for (int i = 0; i < WINDOW; i++) begin
      cls      = slotClass[i*CLASS_W +: CLASS_W];
      canGrant = 1'b0;
      if (!stopRun && slotValid[i]) begin
        if (cls < LS_TAG) begin
          canGrant = !dedFull[cls] && !dedUsed[cls];
        end else if (cls == LS_TAG) begin
          canGrant = !lsFull && (lsCount < lsCap);
        end
      end
      if (canGrant) begin
        strobes.grant[i] = 1'b1;
        if (cls < LS_TAG) begin
          dedUsed[cls]        = 1'b1;
          strobes.dedWe[cls]  = 1'b1;
          strobes.dedSrc[cls] = SLOT_IDX_W'(i);
        end else begin
          strobes.lsWe[lsCount[0]]  = 1'b1;
          strobes.lsSrc[lsCount[0]] = SLOT_IDX_W'(i);
          lsCount = lsCount + 1'b1;
        end
      end else begin
        stopRun = 1'b1;
      end
    end
  end

  // R1: grant run has no holes
  for (genvar g = 1; g < WINDOW; g++) begin : genPrefixChk
    assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.grant[g] |-> strobes.grant[g-1]);
  end

  // R5: a full dedicated queue is never written
  for (genvar q = 0; q < DED_QUEUES; q++) begin : genFullChk
    assert_ded_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dedFull[q] |-> !strobes.dedWe[q]);
  end

  assert_ls_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lsFull |-> (strobes.lsWe == '0));

  assert_ls_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsRoomOne |-> !strobes.lsWe[1]);

  // R3: lane 1 is only used after lane 0
  assert_ls_lane_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.lsWe[1] |-> strobes.lsWe[0]);

  // R2/R3: the number of granted slots matches the queue writes
  assert_grant_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strobes.grant) == $countones(strobes.dedWe) + $countones(strobes.lsWe));
endmodule

// File: rtl/dispatch_write_path.sv
module dispatch_write_path
  import dispatch_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WINDOW*PAY_W-1:0]       slotPayload,
  input  grantStrobes_t                 strobes,
  output logic [DED_QUEUES-1:0]         dedWrEn,
  output logic [DED_QUEUES*PAY_W-1:0]   dedWrData,
  output logic [LS_LANES-1:0]           lsWrEn,
  output logic [LS_LANES*PAY_W-1:0]     lsWrData
);
  for (genvar q = 0; q < DED_QUEUES; q++) begin : genDedLane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dedWrEn[q]                   <= 1'b0;
        dedWrData[q*PAY_W +: PAY_W]  <= '0;
      end else begin
        dedWrEn[q] <= strobes.dedWe[q];
        if (strobes.dedWe[q])
          dedWrData[q*PAY_W +: PAY_W] <= slotPayload[strobes.dedSrc[q]*PAY_W +: PAY_W];
      end
    end
  end

  for (genvar l = 0; l < LS_LANES; l++) begin : genLsLane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lsWrEn[l]                   <= 1'b0;
        lsWrData[l*PAY_W +: PAY_W]  <= '0;
      end else begin
        lsWrEn[l] <= strobes.lsWe[l];
        if (strobes.lsWe[l])
          lsWrData[l*PAY_W +: PAY_W] <= slotPayload[strobes.lsSrc[l]*PAY_W +: PAY_W];
      end
    end
  end

  // R7: every grant turns into exactly one write on the next cycle
  assert_write_follows_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(dedWrEn) + $countones(lsWrEn)) == $countones($past(strobes.grant)));
endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
  import dispatch_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WINDOW-1:0]             slotValid,
  input  logic [WINDOW*CLASS_W-1:0]     slotClass,
  input  logic [WINDOW*PAY_W-1:0]       slotPayload,
  input  logic [DED_QUEUES-1:0]         dedFull,
  input  logic                          lsFull,
  input  logic                          lsRoomOne,
  output logic [WINDOW-1:0]             acceptMask,
  output logic [DED_QUEUES-1:0]         dedWrEn,
  output logic [DED_QUEUES*PAY_W-1:0]   dedWrData,
  output logic [LS_LANES-1:0]           lsWrEn,
  output logic [LS_LANES*PAY_W-1:0]     lsWrData
);
  grantStrobes_t strobes;

  dispatch_grant_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slotValid (slotValid),
    .slotClass (slotClass),
    .dedFull   (dedFull),
    .lsFull    (lsFull),
    .lsRoomOne (lsRoomOne),
    .strobes   (strobes)
  );

  dispatch_write_path uPath (
    .clk         (clk),
    .rst_n       (rst_n),
    .slotPayload (slotPayload),
    .strobes     (strobes),
    .dedWrEn     (dedWrEn),
    .dedWrData   (dedWrData),
    .lsWrEn      (lsWrEn),
    .lsWrData    (lsWrData)
  );

  assign acceptMask = strobes.grant;
endmodule

// File: tb/tb_dispatch_router.sv
module tb_dispatch_router;
  import dispatch_pkg::*;

  logic                          clk = 1'b0;
  logic                          rst_n = 1'b0;
  logic [WINDOW-1:0]             slotValid = '0;
  logic [WINDOW*CLASS_W-1:0]     slotClass = '0;
  logic [WINDOW*PAY_W-1:0]       slotPayload = '0;
  logic [DED_QUEUES-1:0]         dedFull = '0;
  logic                          lsFull = 1'b0;
  logic                          lsRoomOne = 1'b0;
  logic [WINDOW-1:0]             acceptMask;
  logic [DED_QUEUES-1:0]         dedWrEn;
  logic [DED_QUEUES*PAY_W-1:0]   dedWrData;
  logic [LS_LANES-1:0]           lsWrEn;
  logic [LS_LANES*PAY_W-1:0]     lsWrData;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dispatch_router dut (
    .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .slotClass(slotClass),
    .slotPayload(slotPayload), .dedFull(dedFull), .lsFull(lsFull),
    .lsRoomOne(lsRoomOne), .acceptMask(acceptMask), .dedWrEn(dedWrEn),
    .dedWrData(dedWrData), .lsWrEn(lsWrEn), .lsWrData(lsWrData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Fill the window: tags listed oldest first, all valid, payload A000+slot.
  task automatic loadWindow(input int n, input int tags[8]);
    slotValid = '0;
    slotClass = '0;
    for (int i = 0; i < WINDOW; i++) begin
      slotPayload[i*PAY_W +: PAY_W] = 16'hA000 + 16'(i);
      if (i < n) begin
        slotValid[i] = 1'b1;
        slotClass[i*CLASS_W +: CLASS_W] = 3'(tags[i]);
      end
    end
  endtask

  task automatic clearStatus();
    dedFull = '0; lsFull = 1'b0; lsRoomOne = 1'b0;
  endtask

  task automatic testReset();
    chk("R9 dedWrEn in reset", 64'(dedWrEn), 64'h0);
    chk("R9 lsWrEn in reset", 64'(lsWrEn), 64'h0);
  endtask

  task automatic testFullWidth();
    @(negedge clk);
    clearStatus();
    loadWindow(8, '{6, 0, 1, 6, 2, 3, 4, 5});
    #1 chk("R8 full mixed window", 64'(acceptMask), 64'hFF);
    @(negedge clk);
    chk("R7 dedicated enables", 64'(dedWrEn), 64'h3F);
    chk("R7 ls enables", 64'(lsWrEn), 64'h3);
    chk("R7 ls lanes older on lane 0", 64'(lsWrData), 64'hA003_A000);
    chk("R7 queue 2 payload", 64'(dedWrData[2*PAY_W +: PAY_W]), 64'hA004);
    chk("R7 queue 5 payload", 64'(dedWrData[5*PAY_W +: PAY_W]), 64'hA007);
  endtask

  task automatic testDupClass();
    @(negedge clk);
    clearStatus();
    loadWindow(5, '{0, 1, 1, 2, 6, 0, 0, 0});
    #1 chk("R2 duplicate class stalls", 64'(acceptMask), 64'h03);
    @(negedge clk);
    chk("R2 only one write to queue 1", 64'(dedWrEn), 64'h03);
    chk("R1 younger ls not written", 64'(lsWrEn), 64'h0);
  endtask

  task automatic testThreeLs();
    @(negedge clk);
    clearStatus();
    loadWindow(4, '{6, 6, 6, 0, 0, 0, 0, 0});
    #1 chk("R3 third ls stalls", 64'(acceptMask), 64'h03);
    @(negedge clk);
    chk("R3 two ls lanes written", 64'(lsWrEn), 64'h3);
    chk("R1 dedicated behind stall not written", 64'(dedWrEn), 64'h0);
  endtask

  task automatic testRoomOne();
    @(negedge clk);
    clearStatus();
    lsRoomOne = 1'b1;
    loadWindow(4, '{6, 0, 6, 1, 0, 0, 0, 0});
    #1 chk("R4 room for one ls", 64'(acceptMask), 64'h03);
    @(negedge clk);
    chk("R4 one ls lane", 64'(lsWrEn), 64'h1);
    chk("R4 lane 0 payload", 64'(lsWrData[PAY_W-1:0]), 64'hA000);
  endtask

  task automatic testFull();
    @(negedge clk);
    clearStatus();
    dedFull = 6'b000100;
    loadWindow(4, '{0, 1, 2, 3, 0, 0, 0, 0});
    #1 chk("R5 dedicated queue full", 64'(acceptMask), 64'h03);
    @(negedge clk);
    clearStatus();
    lsFull = 1'b1;
    loadWindow(3, '{6, 0, 1, 0, 0, 0, 0, 0});
    #1 chk("R5 ls queue full", 64'(acceptMask), 64'h00);
    @(negedge clk);
    chk("R5 no write when full", 64'({dedWrEn, lsWrEn}), 64'h0);
  endtask

  task automatic testInvalid();
    @(negedge clk);
    clearStatus();
    loadWindow(4, '{0, 1, 2, 3, 0, 0, 0, 0});
    slotValid[2] = 1'b0;
    #1 chk("R6 invalid slot ends run", 64'(acceptMask), 64'h03);
    @(negedge clk);
    loadWindow(3, '{0, 7, 1, 0, 0, 0, 0, 0});
    #1 chk("R6 unrouted tag ends run", 64'(acceptMask), 64'h01);
    @(negedge clk);
    chk("R6 only queue 0 written", 64'(dedWrEn), 64'h01);
    loadWindow(0, '{0, 0, 0, 0, 0, 0, 0, 0});
    #1 chk("R1 empty window", 64'(acceptMask), 64'h00);
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testFullWidth();
    testDupClass();
    testThreeLs();
    testRoomOne();
    testFull();
    testInvalid();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule